// File: doc/BRIEF.md
# Memory-Card Block Read Sequencer

This engine pulls one or more fixed-size data blocks off a memory card over SPI, acting as the bus master. It is meant to run after the multi-block read command has already been issued. A start pulse supplies a byte count and a base address. The engine then generates the serial clock and keeps the outgoing data line high, so that every byte it clocks is all ones. Each received byte is either discarded or written through a simple address/data/strobe port.

For each block, three phases run in turn:

- **Hunt.** Ones bytes are clocked until the card answers with the start token 0xFE. If the token does not arrive within a configured number of bytes, the read stops with an error.
- **Data.** The payload bytes are stored at consecutive addresses, continuing across blocks.
- **Check bytes.** Two trailing check bytes are clocked and dropped.

When the requested count is smaller than one block, a single block is read and only that many payload bytes are stored. Completion and error flags stay set until the next start.

Top module: `sdblk_reader`

## Requirements
- R1: A start pulse with a non-zero byte count while idle sets busy on the next clock edge and clears done and error.
- R2: Each byte is 8 SCLK pulses in SPI mode 0: SCLK idles low, MISO is sampled on the rising edge, MSB first, and each SCLK half-period lasts CLK_DIV clocks. MOSI is 1 at every rising edge. SCLK stays low whenever busy is low.
- R3: During the hunt, each received byte other than 0xFE is dropped without a write. A received 0xFE ends the hunt and is itself not written.
- R4: If MAX_HUNT consecutive hunt bytes are all different from 0xFE, done and error are both set, nothing is written, and no further SCLK pulses follow. A token arriving as hunt byte number MAX_HUNT is still accepted.
- R5: After the token, 2^SECTOR_LOG2 data bytes (512 by default) are each written once. Addresses start at the base and rise by one per byte, continuing across blocks.
- R6: After the data bytes of each block, exactly two more bytes are clocked and never written, even if they equal 0xFE. The next hunt, or completion, follows them.
- R7: The number of blocks is the byte count shifted right by SECTOR_LOG2. Count bits below the block size are ignored when the count is at least one block.
- R8: A byte count between 1 and one less than the block size reads a single block that stores only that many data bytes, then clocks the two check bytes and completes.
- R9: A byte count of zero sets done one clock after start, with error low and no SCLK pulse.
- R10: Done and error hold their values until the next accepted start. A start pulse while busy is ignored and changes neither the transfer in progress nor its results.
- R11: The write strobe is high for exactly one clock per stored data byte, and only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request to begin a read |
| byte_count | input | CNT_W | Number of bytes requested |
| dest_base | input | ADDR_W | First destination address |
| sclk | output | 1 | Serial clock to the card |
| mosi | output | 1 | Outgoing data line, held at 1 |
| miso | input | 1 | Incoming data line from the card |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | ADDR_W | Destination write address |
| wr_data | output | 8 | Destination write data |
| busy | output | 1 | Read in progress |
| done | output | 1 | Read finished (held) |
| error | output | 1 | Token hunt timed out (held) |

## Verification
The bench builds the block with SECTOR_LOG2 = 5 (32-byte blocks), MAX_HUNT = 12 and CLK_DIV = 2. This keeps multi-block reads, remainder bytes in the count, short transfers and the exact hunt-timeout boundary within a few thousand clocks. A modelled card streams wait bytes, the token, payload and check bytes, with 0xFE placed inside payload and check positions. SCLK rising edges are counted per transfer, so hunt, data and check phase lengths are all confirmed at the pins.

// File: rtl/sdblk_pkg.sv
package sdblk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HUNT,
        PH_DATA,
        PH_CRC
    } phase_e;

    localparam logic [7:0] START_TOKEN = 8'hFE;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rx_byte_t;

    function automatic int unsigned div_width(input int unsigned div);
        return (div < 2) ? 1 : $clog2(div + 1);
    endfunction

endpackage

// File: rtl/sdblk_spi_byte.sv
module sdblk_spi_byte
    import sdblk_pkg::*;
#(
    parameter int unsigned CLK_DIV = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  logic     miso,
    output logic     sclk,
    output logic     busy,
    output rx_byte_t rx
);
    localparam int unsigned DIV_W = div_width(CLK_DIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] divc;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             active;
    logic             sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            divc     <= '0;
            bitn     <= '0;
            sh       <= '0;
            active   <= 1'b0;
            sclk_q   <= 1'b0;
            rx       <= '0;
        end else begin
            rx.valid <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    divc   <= '0;
                    bitn   <= '0;
                end
            end else if (divc == DIV_LAST) begin
                divc <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    sh     <= {sh[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bitn == 3'd7) begin
                        active   <= 1'b0;
                        rx.valid <= 1'b1;
                        rx.data  <= sh;
                    end else begin
                        bitn <= bitn + 3'd1;
                    end
                end
            end else begin
                divc <= divc + DIV_W'(1);
            end
        end
    end

    assign sclk = sclk_q;
    assign busy = active;

    // R2: a clock pulse only begins inside an active byte
    a_r2_pulse_in_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_q) |-> active);

endmodule

// File: rtl/sdblk_seq.sv
module sdblk_seq
    import sdblk_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SECTOR_LOG2 = 9,
    parameter int unsigned MAX_HUNT    = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [ADDR_W-1:0] dest_base,
    input  logic              eng_busy,
    input  rx_byte_t          rx,
    output logic              go,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam int unsigned SEC_W  = SECTOR_LOG2 + 1;
    localparam int unsigned HUNT_W = $clog2(MAX_HUNT + 1);
    localparam logic [SEC_W-1:0]  SEC_BYTES = {1'b1, {SECTOR_LOG2{1'b0}}};
    localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(MAX_HUNT - 1);

    phase_e            phase;
    logic [CNT_W-1:0]  sec_left;
    logic [SEC_W-1:0]  per_sec;
    logic [SEC_W-1:0]  data_left;
    logic [HUNT_W-1:0] hunt_cnt;
    logic [ADDR_W-1:0] addr;
    logic              crc_second;
    logic              wait_rx;

    logic [CNT_W-1:0]  req_sectors;
    logic              req_short;

    always_comb begin
        req_sectors = byte_count >> SECTOR_LOG2;
        req_short   = (req_sectors == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            sec_left   <= '0;
            per_sec    <= '0;
            data_left  <= '0;
            hunt_cnt   <= '0;
            addr       <= '0;
            crc_second <= 1'b0;
            wait_rx    <= 1'b0;
            go         <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            done       <= 1'b0;
            error      <= 1'b0;
        end else begin
            go    <= 1'b0;
            wr_en <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    done     <= 1'b0;
                    error    <= 1'b0;
                    addr     <= dest_base;
                    wait_rx  <= 1'b0;
                    hunt_cnt <= '0;
                    if (byte_count == '0) begin
                        done <= 1'b1;
                    end else begin
                        phase    <= PH_HUNT;
                        sec_left <= req_short ? CNT_W'(1) : req_sectors;
                        per_sec  <= req_short ? byte_count[SEC_W-1:0] : SEC_BYTES;
                    end
                end
            end else if (!wait_rx && !eng_busy) begin
                go      <= 1'b1;
                wait_rx <= 1'b1;
            end else if (rx.valid) begin
                wait_rx <= 1'b0;
                case (phase)
                    PH_HUNT: begin
                        if (rx.data == START_TOKEN) begin
                            phase     <= PH_DATA;
                            data_left <= per_sec;
                        end else if (hunt_cnt == HUNT_LAST) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                            error <= 1'b1;
                        end else begin
                            hunt_cnt <= hunt_cnt + HUNT_W'(1);
                        end
                    end
                    PH_DATA: begin
                        wr_en     <= 1'b1;
                        wr_addr   <= addr;
                        wr_data   <= rx.data;
                        addr      <= addr + ADDR_W'(1);
                        data_left <= data_left - SEC_W'(1);
                        if (data_left == SEC_W'(1)) begin
                            phase      <= PH_CRC;
                            crc_second <= 1'b0;
                        end
                    end
                    PH_CRC: begin
                        if (!crc_second) begin
                            crc_second <= 1'b1;
                        end else if (sec_left == CNT_W'(1)) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            sec_left <= sec_left - CNT_W'(1);
                            hunt_cnt <= '0;
                            phase    <= PH_HUNT;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign busy = (phase != PH_IDLE);

    // R3: a hunt byte never produces a write
    a_r3_no_write_from_hunt: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HUNT) |=> !wr_en);

    // R4: an error is always reported together with completion
    a_r4_error_with_done: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

endmodule

// File: rtl/sdblk_reader.sv
module sdblk_reader
    import sdblk_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SECTOR_LOG2 = 9,
    parameter int unsigned MAX_HUNT    = 8192,
    parameter int unsigned CLK_DIV     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [ADDR_W-1:0] dest_base,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic              error
);
    logic     go;
    logic     eng_busy;
    rx_byte_t rx;

    sdblk_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .miso (miso),
        .sclk (sclk),
        .busy (eng_busy),
        .rx   (rx)
    );

    sdblk_seq #(
        .ADDR_W      (ADDR_W),
        .CNT_W       (CNT_W),
        .SECTOR_LOG2 (SECTOR_LOG2),
        .MAX_HUNT    (MAX_HUNT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .byte_count (byte_count),
        .dest_base  (dest_base),
        .eng_busy   (eng_busy),
        .rx         (rx),
        .go         (go),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (busy),
        .done       (done),
        .error      (error)
    );

    assign mosi = 1'b1;

    // R1: completion and activity never overlap
    a_r1_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2: serial clock rests low outside a read
    a_r2_idle_sclk_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R2: a byte request is only issued to an idle shifter
    a_r2_go_when_free: assert property (@(posedge clk) disable iff (rst)
        go |-> !eng_busy);

    // R10: results persist until a new start
    a_r10_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R11: writes happen only during a read
    a_r11_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

endmodule

// File: tb/tb_sdblk_reader.sv
module tb_sdblk_reader;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned SLOG   = 5;
    localparam int unsigned SECB   = 1 << SLOG;
    localparam int unsigned MAXH   = 12;
    localparam int unsigned DIV    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  byte_count = '0;
    logic [ADDR_W-1:0] dest_base = '0;
    logic              sclk, mosi, miso;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              busy, done, error;

    sdblk_reader #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SECTOR_LOG2(SLOG),
        .MAX_HUNT(MAXH), .CLK_DIV(DIV)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
        .dest_base(dest_base), .sclk(sclk), .mosi(mosi), .miso(miso),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .error(error)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } wr_item_t;

    logic [7:0] card_q[$];
    wr_item_t   exp_q[$];

    int n_chk = 0, n_fail = 0;
    int mon_chk = 0, mon_fail = 0;
    int sclk_rises = 0, mosi_bad = 0;
    logic [ADDR_W-1:0] next_addr;

    // card model: mode 0, next bit presented on each falling edge
    logic       arm = 1'b0;
    logic [7:0] card_sh = 8'hFF;
    int         card_nb = 0;
    always @(posedge arm or negedge sclk) begin
        if (arm || card_nb == 7) begin
            card_sh = (card_q.size() > 0) ? card_q.pop_front() : 8'hFF;
            card_nb = 0;
        end else begin
            card_sh = {card_sh[6:0], 1'b1};
            card_nb++;
        end
    end
    assign miso = card_sh[7];

    always @(posedge sclk) begin
        sclk_rises++;
        if (mosi !== 1'b1) mosi_bad++;
    end

    // monitor: pops the scoreboard on every write strobe
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            mon_chk++;
            if (exp_q.size() == 0) begin
                mon_fail++;
                $display("FAIL R11 unexpected write addr=%0h data=%0h expected none", wr_addr, wr_data);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                if (wr_addr !== e.addr || wr_data !== e.data) begin
                    mon_fail++;
                    $display("FAIL R5 write addr/data=%0h/%0h expected %0h/%0h",
                             wr_addr, wr_data, e.addr, e.data);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one block of card traffic and its expected writes
    task automatic push_block(input int nwait, input int ndata, input int seed, input bit store);
        for (int i = 0; i < nwait; i++) card_q.push_back(8'hFF);
        card_q.push_back(8'hFE);
        for (int i = 0; i < ndata; i++) begin
            logic [7:0] d;
            d = 8'((seed + i * 7) & 8'hFF);
            if (i == 3) d = 8'hFE;
            card_q.push_back(d);
            if (store) begin
                exp_q.push_back('{addr: next_addr, data: d});
                next_addr = next_addr + ADDR_W'(1);
            end
        end
        card_q.push_back(8'hFE);
        card_q.push_back(8'h5A);
    endtask

    task automatic launch(input int cnt, input logic [ADDR_W-1:0] base);
        @(negedge clk);
        arm = 1'b1;
        #1 arm = 1'b0;
        byte_count = CNT_W'(cnt);
        dest_base  = base;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done;
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    endtask

    task automatic finish_xfer(input string tag, input int exp_bytes, input int rises0, input bit exp_err);
        wait_done();
        check(done === 1'b1, {tag, " done"}, int'(done), 1);
        check(error === exp_err, {tag, " error"}, int'(error), int'(exp_err));
        check(sclk_rises - rises0 == exp_bytes * 8, {tag, " sclk pulses"},
              sclk_rises - rises0, exp_bytes * 8);
        check(exp_q.size() == 0, {tag, " writes outstanding"}, exp_q.size(), 0);
        card_q.delete();
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1 reset flags",
              int'({busy, done, error}), 0);
        check(sclk === 1'b0 && wr_en === 1'b0 && mosi === 1'b1, "R2 reset pins",
              int'({sclk, wr_en, mosi}), 1);

        // single full block (R5, R6, R3)
        next_addr = 12'h100;
        push_block(3, SECB, 8'h11, 1'b1);
        r0 = sclk_rises;
        launch(SECB, 12'h100);
        check(busy === 1'b1 && done === 1'b0, "R1 busy after start", int'({busy, done}), 2);
        finish_xfer("R5 single block", 4 + SECB + 2, r0, 1'b0);

        // three blocks plus remainder bytes (R7, R6)
        next_addr = 12'h200;
        push_block(5, SECB, 8'h20, 1'b1);
        push_block(0, SECB, 8'h40, 1'b1);
        push_block(2, SECB, 8'h60, 1'b1);
        r0 = sclk_rises;
        launch(3 * SECB + 5, 12'h200);
        finish_xfer("R7 multi block", (6 + SECB + 2) + (1 + SECB + 2) + (3 + SECB + 2), r0, 1'b0);

        // short transfer (R8)
        next_addr = 12'h080;
        push_block(1, 10, 8'h33, 1'b1);
        r0 = sclk_rises;
        launch(10, 12'h080);
        finish_xfer("R8 short", 2 + 10 + 2, r0, 1'b0);

        // timeout (R4): no token at all
        r0 = sclk_rises;
        launch(SECB, 12'h400);
        finish_xfer("R4 timeout", MAXH, r0, 1'b1);
        repeat (40) @(negedge clk);
        check(sclk_rises == r0 + MAXH * 8, "R4 no pulses after error", sclk_rises - r0, MAXH * 8);
        check(error === 1'b1, "R10 error held", int'(error), 1);

        // token as the last allowed hunt byte (R4 boundary), start clears error (R1)
        next_addr = 12'h500;
        push_block(MAXH - 1, SECB, 8'h77, 1'b1);
        r0 = sclk_rises;
        launch(SECB, 12'h500);
        check(error === 1'b0 && done === 1'b0, "R1 flags cleared", int'({done, error}), 0);
        finish_xfer("R4 boundary", MAXH + SECB + 2, r0, 1'b0);

        // zero count (R9)
        r0 = sclk_rises;
        launch(0, 12'h600);
        check(done === 1'b1 && busy === 1'b0, "R9 immediate done", int'({done, busy}), 2);
        finish_xfer("R9 zero", 0, r0, 1'b0);

        // start while busy ignored (R10)
        next_addr = 12'h300;
        push_block(2, SECB, 8'h90, 1'b1);
        r0 = sclk_rises;
        launch(SECB, 12'h300);
        repeat (40) @(negedge clk);
        byte_count = CNT_W'(2 * SECB);
        dest_base  = 12'h700;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_xfer("R10 start ignored", 3 + SECB + 2, r0, 1'b0);
        repeat (30) @(negedge clk);
        check(done === 1'b1 && busy === 1'b0, "R10 done held", int'({done, busy}), 2);
        check(mosi_bad == 0, "R2 mosi high on every rising edge", mosi_bad, 0);

        $display("%0d/%0d checks passed", (n_chk + mon_chk) - (n_fail + mon_fail), n_chk + mon_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", (n_chk + mon_chk) - (n_fail + mon_fail), n_chk + mon_chk + 1);
        $finish;
    end

endmodule